// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block joins two processors that run from unrelated clocks. It gives them eight persistent byte ports. Four ports carry bytes from side A to side B, and four carry bytes from side B to side A. Each side has its own clock, reset, address, write data, read strobe and write strobe.

A port keeps the last byte written into it. The other side can read that byte as often as it likes, until the writer replaces it. Nothing is consumed and there is no empty state. Neither side can interrupt the other, so software finds new data by polling for a changed value.

Side A sees the four ports through a 64-byte window that repeats every four bytes. Side B sees the ports at four consecutive addresses starting at a 4-aligned base in its low page. Every side-B write, including one that hits a port, is also passed straight on to side B's local RAM. Side B can also zero its four inbound ports with one clear strobe.

Each byte crosses between the clock domains through a holding register and a toggle flag. The toggle goes through two flops, so a reader never sees a half-changed byte. This stays correct while the ratio of the two clocks drifts.

Top module: `mbx_link`

## Requirements
- R1: After reset, every port reads as 0x00 from both sides.
- R2: A port keeps its value: repeated reads of a port that has not been written again return the same byte, however long the gap between them.
- R3: A read returns only the byte written by the opposite side. A side's own write to port n, even in the same cycle as its read of port n, does not change what that read returns.
- R4: A side-A write to port k (k = a_addr[1:0]) can be read at side-B address PORT_BASE+k within 8 side-B cycles.
- R5: A side-B write to address PORT_BASE+k can be read from side-A port k within 8 side-A cycles.
- R6: Side A decodes only a_addr[1:0]. Every one of the 64 window addresses with the same two low bits reaches the same port.
- R7: Every side-B write drives b_ram_we high in the same cycle, with b_ram_addr equal to b_addr and b_ram_wdata equal to b_wdata. This includes writes that hit a port.
- R8: A one-cycle b_clr pulse makes all four A-to-B ports read as 0x00 from side B, starting the next cycle. It leaves the B-to-A ports unchanged. A side-B read in the same cycle as the clear returns the value from before the clear.
- R9: A side-B write outside PORT_BASE..PORT_BASE+3 changes no port.
- R10: Read data is registered. a_rdata and b_rdata change only in the cycle after a read strobe, and hold their value otherwise, even when the port underneath changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_addr | input | A_ADDR_W | Side A window offset |
| a_wdata | input | DATA_W | Side A write byte |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_rdata | output | DATA_W | Side A registered read byte |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_addr | input | B_ADDR_W | Side B address |
| b_wdata | input | DATA_W | Side B write byte |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (port range only) |
| b_clr | input | 1 | Zero the inbound A-to-B ports |
| b_rdata | output | DATA_W | Side B registered read byte |
| b_ram_we | output | 1 | Write strobe passed on to side B RAM |
| b_ram_addr | output | B_ADDR_W | Address passed on to side B RAM |
| b_ram_wdata | output | DATA_W | Data passed on to side B RAM |

## Verification
Two functions can fall in the same cycle on one side.

The first pair is a side's own write to port n and its read of port n. The bench asserts a_wr and a_rd on the same edge with the same offset. It expects the read to return the byte last sent by side B. Later, a side-B read must show the newly written byte.

The second pair is the side-B clear and a side-B read. The bench raises b_clr and b_rd together. It expects the pre-clear byte from that read and 0x00 from the reads that follow.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NUM_PORTS  = 4;
    localparam int PORT_SEL_W = $clog2(NUM_PORTS);

    typedef logic [PORT_SEL_W-1:0] port_sel_t;

    typedef struct packed {
        logic      hit;
        port_sel_t idx;
    } port_hit_t;
endpackage

// File: rtl/mbx_lane.sv
module mbx_lane #(
    parameter int DATA_W = 8
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_we,
    input  logic [DATA_W-1:0] src_wdata,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic              dst_clr,
    output logic [DATA_W-1:0] dst_val
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              tog;
    } src_t;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              s1;
        logic              s2;
        logic              seen;
    } dst_t;

    src_t src_d, src_q;
    dst_t dst_d, dst_q;
    logic arrive;

    always_comb begin
        src_d = src_q;
        if (src_we) begin
            src_d.hold = src_wdata;
            src_d.tog  = ~src_q.tog;
        end
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) src_q <= '0;
        else            src_q <= src_d;
    end

    assign arrive = dst_q.s2 ^ dst_q.seen;

    always_comb begin
        dst_d      = dst_q;
        dst_d.s1   = src_q.tog;
        dst_d.s2   = dst_q.s1;
        dst_d.seen = dst_q.s2;
        if (arrive)       dst_d.val = src_q.hold;
        else if (dst_clr) dst_d.val = '0;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_q <= '0;
        else            dst_q <= dst_d;
    end

    assign dst_val = dst_q.val;

    // R2: with no arrival and no clear the reader copy holds
    assert_keep_R2: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (!arrive && !dst_clr) |=> $stable(dst_q.val));

    // R8: a clear without a competing arrival zeroes the copy
    assert_clear_R8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (!arrive && dst_clr) |=> (dst_q.val == '0));

    // R4/R5: every accepted write flips the crossing flag
    assert_flip_R4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_we |=> (src_q.tog != $past(src_q.tog)));
endmodule

// File: rtl/mbx_bdec.sv
module mbx_bdec
    import mbx_pkg::*;
#(
    parameter int                B_ADDR_W  = 16,
    parameter logic [B_ADDR_W-1:0] PORT_BASE = 16'h0010
) (
    input  logic [B_ADDR_W-1:0] addr,
    output port_hit_t           dec
);
    logic [B_ADDR_W-1:0] offset;

    always_comb begin
        dec.hit = (addr[B_ADDR_W-1:PORT_SEL_W] == PORT_BASE[B_ADDR_W-1:PORT_SEL_W]);
        dec.idx = addr[PORT_SEL_W-1:0];
        offset  = addr - PORT_BASE;
    end

    // R9: a decoded hit lies within the four-byte port range
    always_comb begin
        if (dec.hit === 1'b1)
            assert_range_R9: assert (offset < B_ADDR_W'(NUM_PORTS));
    end
endmodule

// File: rtl/mbx_link.sv
module mbx_link
    import mbx_pkg::*;
#(
    parameter int                  DATA_W    = 8,
    parameter int                  A_ADDR_W  = 6,
    parameter int                  B_ADDR_W  = 16,
    parameter logic [B_ADDR_W-1:0] PORT_BASE = 16'h0010
) (
    input  logic                clk_a,
    input  logic                rst_a_n,
    input  logic [A_ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0]   a_wdata,
    input  logic                a_wr,
    input  logic                a_rd,
    output logic [DATA_W-1:0]   a_rdata,
    input  logic                clk_b,
    input  logic                rst_b_n,
    input  logic [B_ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0]   b_wdata,
    input  logic                b_wr,
    input  logic                b_rd,
    input  logic                b_clr,
    output logic [DATA_W-1:0]   b_rdata,
    output logic                b_ram_we,
    output logic [B_ADDR_W-1:0] b_ram_addr,
    output logic [DATA_W-1:0]   b_ram_wdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    logic [DATA_W-1:0] a2b_val [NUM_PORTS];
    logic [DATA_W-1:0] b2a_val [NUM_PORTS];
    port_sel_t         a_idx;
    port_hit_t         b_dec;
    logic              unused_a_hi;
    rd_t               ra_d, ra_q, rb_d, rb_q;

    assign a_idx       = a_addr[PORT_SEL_W-1:0];
    assign unused_a_hi = ^a_addr[A_ADDR_W-1:PORT_SEL_W];

    mbx_bdec #(.B_ADDR_W(B_ADDR_W), .PORT_BASE(PORT_BASE)) u_bdec (
        .addr (b_addr),
        .dec  (b_dec)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        mbx_lane #(.DATA_W(DATA_W)) u_a2b (
            .src_clk   (clk_a),
            .src_rst_n (rst_a_n),
            .src_we    (a_wr && (a_idx == port_sel_t'(i))),
            .src_wdata (a_wdata),
            .dst_clk   (clk_b),
            .dst_rst_n (rst_b_n),
            .dst_clr   (b_clr),
            .dst_val   (a2b_val[i])
        );
        mbx_lane #(.DATA_W(DATA_W)) u_b2a (
            .src_clk   (clk_b),
            .src_rst_n (rst_b_n),
            .src_we    (b_wr && b_dec.hit && (b_dec.idx == port_sel_t'(i))),
            .src_wdata (b_wdata),
            .dst_clk   (clk_a),
            .dst_rst_n (rst_a_n),
            .dst_clr   (1'b0),
            .dst_val   (b2a_val[i])
        );
    end

    always_comb begin
        ra_d = ra_q;
        if (a_rd) ra_d.rdata = b2a_val[a_idx];
        rb_d = rb_q;
        if (b_rd && b_dec.hit) rb_d.rdata = a2b_val[b_dec.idx];
    end

    always_ff @(posedge clk_a or negedge rst_a_n) begin
        if (!rst_a_n) ra_q <= '0;
        else          ra_q <= ra_d;
    end

    always_ff @(posedge clk_b or negedge rst_b_n) begin
        if (!rst_b_n) rb_q <= '0;
        else          rb_q <= rb_d;
    end

    assign a_rdata     = ra_q.rdata;
    assign b_rdata     = rb_q.rdata;
    assign b_ram_we    = b_wr;
    assign b_ram_addr  = b_addr;
    assign b_ram_wdata = b_wdata;

    // R10: without a read strobe side A's read data holds
    assert_rhold_a_R10: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !a_rd |=> $stable(a_rdata));

    // R10: without a port read side B's read data holds
    assert_rhold_b_R10: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !b_rd |=> $stable(b_rdata));
endmodule

// File: tb/mbx_link_test.sv
module mbx_link_test;
    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = CLK_PERIOD * 2 + 4;
    localparam logic [15:0] BASE = 16'h0010;

    logic        clk_a = 0, clk_b = 0;
    logic        rst_a_n = 0, rst_b_n = 0;
    logic [5:0]  a_addr = '0;
    logic [7:0]  a_wdata = '0;
    logic        a_wr = 0, a_rd = 0;
    logic [7:0]  a_rdata;
    logic [15:0] b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic        b_wr = 0, b_rd = 0, b_clr = 0;
    logic [7:0]  b_rdata;
    logic        b_ram_we;
    logic [15:0] b_ram_addr;
    logic [7:0]  b_ram_wdata;

    int checks = 0, fails = 0;
    logic [7:0] qa_exp[$], qb_exp[$];
    string      qa_tag[$], qb_tag[$];
    logic       a_pend = 0, b_pend = 0;
    logic [7:0] held;

    always #(CLK_PERIOD/2)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mbx_link uut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_wr(a_wr), .a_rd(a_rd), .a_rdata(a_rdata),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_wr(b_wr), .b_rd(b_rd), .b_clr(b_clr), .b_rdata(b_rdata),
        .b_ram_we(b_ram_we), .b_ram_addr(b_ram_addr), .b_ram_wdata(b_ram_wdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitors: pop expected read data the cycle after the strobe
    always @(posedge clk_a) a_pend <= a_rd;
    always @(posedge clk_b) b_pend <= b_rd;
    always @(negedge clk_a) if (a_pend && qa_exp.size() > 0)
        check(qa_tag.pop_front(), {24'h0, a_rdata}, {24'h0, qa_exp.pop_front()});
    always @(negedge clk_b) if (b_pend && qb_exp.size() > 0)
        check(qb_tag.pop_front(), {24'h0, b_rdata}, {24'h0, qb_exp.pop_front()});

    task automatic a_read(logic [5:0] ad, logic [7:0] exp, string tag);
        @(negedge clk_a);
        a_addr = ad; a_rd = 1; qa_exp.push_back(exp); qa_tag.push_back(tag);
        @(negedge clk_a); a_rd = 0;
    endtask

    task automatic a_write(logic [5:0] ad, logic [7:0] d);
        @(negedge clk_a);
        a_addr = ad; a_wdata = d; a_wr = 1;
        @(negedge clk_a); a_wr = 0;
    endtask

    task automatic b_read(logic [15:0] ad, logic [7:0] exp, string tag);
        @(negedge clk_b);
        b_addr = ad; b_rd = 1; qb_exp.push_back(exp); qb_tag.push_back(tag);
        @(negedge clk_b); b_rd = 0;
    endtask

    task automatic b_write(logic [15:0] ad, logic [7:0] d);
        @(negedge clk_b);
        b_addr = ad; b_wdata = d; b_wr = 1;
        #1;
        check("R7 ram_we", {31'h0, b_ram_we}, 32'h1);
        check("R7 ram_addr", {16'h0, b_ram_addr}, {16'h0, ad});
        check("R7 ram_wdata", {24'h0, b_ram_wdata}, {24'h0, d});
        @(negedge clk_b); b_wr = 0;
    endtask

    task automatic wait_b(int n);
        repeat (n) @(negedge clk_b);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk_b);
        rst_a_n = 1; rst_b_n = 1;
        wait_b(2);

        // R1 reset state
        for (int k = 0; k < 4; k++) a_read(6'(k), 8'h00, "R1 a");
        for (int k = 0; k < 4; k++) b_read(BASE + 16'(k), 8'h00, "R1 b");

        // R4 A to B
        for (int k = 0; k < 4; k++) a_write(6'(k), 8'hA0 + 8'(k));
        wait_b(8);
        for (int k = 0; k < 4; k++) b_read(BASE + 16'(k), 8'hA0 + 8'(k), "R4");

        // R5 B to A, read back through mirrored addresses (R6)
        for (int k = 0; k < 4; k++) b_write(BASE + 16'(k), 8'h50 + 8'(k));
        wait_b(4);
        a_read(6'h00, 8'h50, "R5");
        a_read(6'h24, 8'h50, "R6 mirror 0x24");
        a_read(6'h3D, 8'h51, "R6 mirror 0x3D");
        a_read(6'h16, 8'h52, "R6 mirror 0x16");
        a_read(6'h3F, 8'h53, "R6 mirror 0x3F");

        // R2 persistence across a long gap
        wait_b(40);
        a_read(6'h02, 8'h52, "R2 a");
        a_read(6'h02, 8'h52, "R2 a again");
        b_read(BASE + 16'd2, 8'hA2, "R2 b");

        // R3 own write and own read of port 1 in one cycle
        @(negedge clk_a);
        a_addr = 6'h01; a_wdata = 8'hEE; a_wr = 1; a_rd = 1;
        qa_exp.push_back(8'h51); qa_tag.push_back("R3 same-cycle");
        @(negedge clk_a); a_wr = 0; a_rd = 0;
        a_read(6'h01, 8'h51, "R3 after");
        wait_b(8);
        b_read(BASE + 16'd1, 8'hEE, "R4 port1 update");

        // R9 writes outside the port range
        b_write(BASE + 16'd4, 8'h99);
        b_write(BASE - 16'd1, 8'h98);
        b_write(16'h0110, 8'h97);
        wait_b(8);
        a_read(6'h03, 8'h53, "R9 port3");
        a_read(6'h00, 8'h50, "R9 port0");

        // R10 read data holds while the port changes underneath
        b_read(BASE + 16'd3, 8'hA3, "R10 setup");
        wait_b(1);
        held = b_rdata;
        a_write(6'h03, 8'h77);
        wait_b(8);
        check("R10 hold b", {24'h0, b_rdata}, {24'h0, held});
        b_read(BASE + 16'd3, 8'h77, "R10 fresh");

        // R8 clear together with a read
        @(negedge clk_b);
        b_addr = BASE; b_rd = 1; b_clr = 1;
        qb_exp.push_back(8'hA0); qb_tag.push_back("R8 read with clear");
        @(negedge clk_b); b_rd = 0; b_clr = 0;
        for (int k = 0; k < 4; k++) b_read(BASE + 16'(k), 8'h00, "R8 cleared");
        a_read(6'h02, 8'h52, "R8 B-to-A kept");

        wait_b(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule